// File: doc/BRIEF.md
# Cassette Controller Command and Status Register

This block is the host-facing register file of a two-drive cassette tape controller. It holds an 8-bit command register, which selects a drive and a function and carries the enable and interrupt-enable controls. It also holds a 9-bit error and status word. The host reaches it through single-cycle I/O sub-operations: clear, load command, read status, go, and four skip tests. Each sub-operation returns its result in the same cycle on `rd_data_o` and `skip_o`.

The status word mixes sticky error bits with dynamic bits. The sticky bits are set by the transfer sequencer or by the go logic. The dynamic bits are derived each cycle from the presence, write-protect and busy inputs of the drive being tracked. The host sees the status word only while the enable bit is set. A go request becomes either a start pulse or a continue pulse to the sequencer one cycle later. A start is refused when the controller is disabled or the drive is missing. A write-type start on a protected drive is aborted and latches a write-lock error. A level interrupt request is raised when interrupts are enabled and the data flag, an error bit or the ready bit is set.

Top module: `tape_csr`

## Requirements
- R1: While `rst_ni` is low the design clears the command register, every sticky status bit and the data flag. After reset `irq_o`, `skip_o`, `go_start_o` and `go_cont_o` are 0, and a status read returns 0.
- R2: Sub-op 4 (load) stores `host_data_i` into the command register at the clock edge and returns `host_data_i` XOR 8'hFF on `rd_data_o` in the same cycle. Command layout: bit 7 enable, bit 6 drive select, bits 5:3 function, bit 0 interrupt enable.
- R3: While the enable bit is 0 the visible status is all zero: sub-op 7 returns 0, and status bits do not contribute to skips or to the interrupt.
- R4: Sub-op 7 returns visible status bits 7:0. Status layout: bit 8 write-lock error, 7 CRC error, 6 timing error, 5 BOT/EOT, 4 end of file, 3 drive empty, 2 rewinding, 1 write locked, 0 ready. The tracked drive is the lowest-numbered busy drive, or the selected drive when none is busy. Bit 3 is set when the tracked drive is absent. Bit 0 is set when it is not busy. Bit 2 is set only when the rewind latch is set and the tracked drive is both present and busy.
- R5: Status bit 1 is set when the tracked drive is absent, write protected, or shown as rewinding.
- R6: Sub-op 1 skips when the data flag is set. `df_set_i` sets the data flag. Sub-op 6 clears it, but a same-cycle `df_set_i` wins.
- R7: Sub-op 2 skips when any of visible status bits 8 to 3 is set.
- R8: Sub-op 3 skips when ready is set and empty is clear. Sub-op 5 skips on the data flag, on any error bit (8 to 3), or on ready. No other sub-op skips.
- R9: `irq_o` equals command bit 0 AND (data flag OR any visible error bit OR visible ready). It is combinational.
- R10: Sub-op 6 starts an operation when no drive is busy, enable is set, the selected drive is present and the start is not write-blocked. A start clears status bits 8, 7, 6, 5, 4 and the rewind latch, and sets the rewind latch when the function is 1. In the next cycle `go_start_o` pulses with `go_fn_o` and `go_unit_o` taken from the command. When enable is clear or the drive is absent, sub-op 6 changes nothing and sends no pulse.
- R11: A start with a write-type function (2 or 4) on a write-protected selected drive clears bits 7, 6, 4 and the rewind latch, sets bit 8, and leaves bit 5 unchanged. No start pulse is sent.
- R12: Sub-op 6 while any drive is busy pulses `go_cont_o` in the next cycle and leaves the status unchanged. `go_start_o` and `go_cont_o` are never high together.
- R13: `df_set_i` while the data flag is already set, with no sub-op 6 in the same cycle, sets timing error bit 6. `crc_err_i`, `eof_i` and `beot_i` set bits 7, 4 and 5. These sets take precedence over the clearing done by a start in the same cycle.
- R14: Sub-op 0 clears the command register, all sticky status bits and the data flag at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| iot_valid_i | input | 1 | Host sub-operation valid this cycle |
| iot_op_i | input | 3 | Sub-operation code 0..7 |
| host_data_i | input | 8 | Host data word |
| drv_present_i | input | NUM_DRIVES | Cassette loaded, per drive |
| drv_wprot_i | input | NUM_DRIVES | Write protected, per drive |
| drv_busy_i | input | NUM_DRIVES | Drive in motion, per drive |
| df_set_i | input | 1 | Sequencer sets the data flag |
| crc_err_i | input | 1 | Sequencer reports a CRC error |
| eof_i | input | 1 | Sequencer reports end of file |
| beot_i | input | 1 | Sequencer reports BOT/EOT |
| rd_data_o | output | 8 | Value returned to the host |
| skip_o | output | 1 | Skip result of the current sub-op |
| irq_o | output | 1 | Level interrupt request |
| go_start_o | output | 1 | One-cycle start pulse to the sequencer |
| go_cont_o | output | 1 | One-cycle continue pulse to the sequencer |
| go_fn_o | output | 3 | Function latched with the last pulse |
| go_unit_o | output | UNIT_W | Drive latched with the last pulse |

## Verification
The bench builds the block with the default NUM_DRIVES of 2, so a one-bit select field and two drives with independent presence, protection and busy inputs are in play. With two drives the lowest-busy-drive priority becomes reachable. So do the cases where the tracked drive differs from the selected drive, and where a busy drive forces continue pulses regardless of the selection. Random sub-ops mixed with sequencer events also exercise a start that collides with sticky-bit sets, and a data-flag set that collides with a go request.

// File: rtl/tape_csr_pkg.sv
package tape_csr_pkg;
  localparam int CMD_W = 8;
  localparam int STAT_W = 9;

  localparam int CMD_EN_BIT = 7;
  localparam int CMD_UNIT_LSB = 6;
  localparam int CMD_FN_LSB = 3;
  localparam int CMD_IE_BIT = 0;

  localparam int ST_WLE = 8;
  localparam int ST_CRC = 7;
  localparam int ST_TIM = 6;
  localparam int ST_BEOT = 5;
  localparam int ST_EOF = 4;
  localparam int ST_EMPTY = 3;
  localparam int ST_REW = 2;
  localparam int ST_WLK = 1;
  localparam int ST_RDY = 0;

  localparam logic [STAT_W-1:0] ERR_MASK = 9'b1_1111_1000;

  typedef enum logic [2:0] {
    IOP_CLEAR    = 3'd0,
    IOP_SKIP_DF  = 3'd1,
    IOP_SKIP_ERR = 3'd2,
    IOP_SKIP_RDY = 3'd3,
    IOP_LOAD     = 3'd4,
    IOP_SKIP_ANY = 3'd5,
    IOP_GO       = 3'd6,
    IOP_RD_STAT  = 3'd7
  } iot_op_e;

  typedef enum logic [2:0] {
    FN_READ      = 3'd0,
    FN_REWIND    = 3'd1,
    FN_WRITE     = 3'd2,
    FN_SP_RFILE  = 3'd3,
    FN_WR_GAP    = 3'd4,
    FN_SP_RBLK   = 3'd5,
    FN_CRC       = 3'd6,
    FN_SP_FFILE  = 3'd7
  } tape_fn_e;

  function automatic logic fn_writes(tape_fn_e f);
    return (f == FN_WRITE) || (f == FN_WR_GAP);
  endfunction
endpackage

// File: rtl/tape_csr_cmd_reg.sv
module tape_csr_cmd_reg
  import tape_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CMD_W-1:0] data_i,
  output logic [CMD_W-1:0] cmd_o
);
  logic [CMD_W-1:0] cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (clr_i) begin
      cmd_q <= '0;
    end else if (load_i) begin
      cmd_q <= data_i;
    end
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/tape_csr_unit_sel.sv
module tape_csr_unit_sel #(
  parameter int NUM_DRIVES = 2,
  parameter int UNIT_W = 1
) (
  input  logic [UNIT_W-1:0]     sel_unit_i,
  input  logic [NUM_DRIVES-1:0] present_i,
  input  logic [NUM_DRIVES-1:0] wprot_i,
  input  logic [NUM_DRIVES-1:0] busy_i,
  output logic                  any_busy_o,
  output logic [UNIT_W-1:0]     cur_unit_o,
  output logic                  cur_present_o,
  output logic                  cur_wprot_o,
  output logic                  cur_busy_o
);
  logic [UNIT_W-1:0] cur_unit;

  // lowest-numbered busy drive wins; otherwise the selected drive
  always_comb begin
    cur_unit = sel_unit_i;
    for (int i = NUM_DRIVES - 1; i >= 0; i--) begin
      if (busy_i[i]) cur_unit = UNIT_W'(i);
    end
  end

  assign any_busy_o    = |busy_i;
  assign cur_unit_o    = cur_unit;
  assign cur_present_o = present_i[cur_unit];
  assign cur_wprot_o   = wprot_i[cur_unit];
  assign cur_busy_o    = busy_i[cur_unit];
endmodule

// File: rtl/tape_csr_status.sv
module tape_csr_status
  import tape_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              rewind_i,
  input  logic              df_set_i,
  input  logic              df_clr_i,
  input  logic              crc_set_i,
  input  logic              eof_set_i,
  input  logic              beot_set_i,
  input  logic              enable_i,
  input  logic              cur_present_i,
  input  logic              cur_wprot_i,
  input  logic              cur_busy_i,
  output logic [STAT_W-1:0] vis_stat_o,
  output logic              df_o
);
  logic wle_q, crc_q, tim_q, beot_q, eof_q, rew_q, df_q;
  logic wle_d, crc_d, tim_d, beot_d, eof_d, rew_d, df_d;

  always_comb begin
    wle_d  = wle_q;
    crc_d  = crc_q;
    tim_d  = tim_q;
    beot_d = beot_q;
    eof_d  = eof_q;
    rew_d  = rew_q;
    df_d   = df_q;

    if (start_i || abort_i) begin
      wle_d = 1'b0;
      crc_d = 1'b0;
      tim_d = 1'b0;
      eof_d = 1'b0;
      rew_d = 1'b0;
    end
    if (abort_i) begin
      wle_d = 1'b1;
    end
    if (start_i) begin
      beot_d = 1'b0;
      rew_d  = rewind_i;
    end

    if (df_clr_i) df_d = 1'b0;
    if (df_set_i) begin
      if (df_q && !df_clr_i) tim_d = 1'b1;
      df_d = 1'b1;
    end

    // sequencer events take precedence over start clearing
    if (crc_set_i)  crc_d  = 1'b1;
    if (eof_set_i)  eof_d  = 1'b1;
    if (beot_set_i) beot_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wle_q  <= 1'b0;
      crc_q  <= 1'b0;
      tim_q  <= 1'b0;
      beot_q <= 1'b0;
      eof_q  <= 1'b0;
      rew_q  <= 1'b0;
      df_q   <= 1'b0;
    end else if (clr_i) begin
      wle_q  <= 1'b0;
      crc_q  <= 1'b0;
      tim_q  <= 1'b0;
      beot_q <= 1'b0;
      eof_q  <= 1'b0;
      rew_q  <= 1'b0;
      df_q   <= 1'b0;
    end else begin
      wle_q  <= wle_d;
      crc_q  <= crc_d;
      tim_q  <= tim_d;
      beot_q <= beot_d;
      eof_q  <= eof_d;
      rew_q  <= rew_d;
      df_q   <= df_d;
    end
  end

  logic              empty, rew_vis, wlk, rdy;
  logic [STAT_W-1:0] raw_stat;

  // rewinding is shown only while the tracked drive is loaded and moving
  assign empty   = !cur_present_i;
  assign rew_vis = rew_q && cur_present_i && cur_busy_i;
  assign wlk     = empty || cur_wprot_i || rew_vis;
  assign rdy     = !cur_busy_i;

  always_comb begin
    raw_stat           = '0;
    raw_stat[ST_WLE]   = wle_q;
    raw_stat[ST_CRC]   = crc_q;
    raw_stat[ST_TIM]   = tim_q;
    raw_stat[ST_BEOT]  = beot_q;
    raw_stat[ST_EOF]   = eof_q;
    raw_stat[ST_EMPTY] = empty;
    raw_stat[ST_REW]   = rew_vis;
    raw_stat[ST_WLK]   = wlk;
    raw_stat[ST_RDY]   = rdy;
  end

  assign vis_stat_o = enable_i ? raw_stat : '0;
  assign df_o       = df_q;
endmodule

// File: rtl/tape_csr_host_dec.sv
module tape_csr_host_dec
  import tape_csr_pkg::*;
(
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [CMD_W-1:0]  data_i,
  input  logic [STAT_W-1:0] vis_stat_i,
  input  logic              df_i,
  input  logic              ie_i,
  output logic [CMD_W-1:0]  rd_data_o,
  output logic              skip_o,
  output logic              irq_o
);
  logic err_any, rdy, empty;

  assign err_any = |(vis_stat_i & ERR_MASK);
  assign rdy     = vis_stat_i[ST_RDY];
  assign empty   = vis_stat_i[ST_EMPTY];

  always_comb begin
    skip_o    = 1'b0;
    rd_data_o = data_i;
    if (valid_i) begin
      unique case (iot_op_e'(op_i))
        IOP_SKIP_DF:  skip_o = df_i;
        IOP_SKIP_ERR: skip_o = err_any;
        IOP_SKIP_RDY: skip_o = rdy && !empty;
        IOP_SKIP_ANY: skip_o = df_i || err_any || rdy;
        IOP_LOAD:     rd_data_o = ~data_i;
        IOP_RD_STAT:  rd_data_o = vis_stat_i[CMD_W-1:0];
        default:      skip_o = 1'b0;
      endcase
    end
  end

  assign irq_o = ie_i && (df_i || err_any || rdy);
endmodule

// File: rtl/tape_csr.sv
module tape_csr
  import tape_csr_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  localparam int UNIT_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  iot_valid_i,
  input  logic [2:0]            iot_op_i,
  input  logic [7:0]            host_data_i,
  input  logic [NUM_DRIVES-1:0] drv_present_i,
  input  logic [NUM_DRIVES-1:0] drv_wprot_i,
  input  logic [NUM_DRIVES-1:0] drv_busy_i,
  input  logic                  df_set_i,
  input  logic                  crc_err_i,
  input  logic                  eof_i,
  input  logic                  beot_i,
  output logic [7:0]            rd_data_o,
  output logic                  skip_o,
  output logic                  irq_o,
  output logic                  go_start_o,
  output logic                  go_cont_o,
  output logic [2:0]            go_fn_o,
  output logic [UNIT_W-1:0]     go_unit_o
);
  logic [CMD_W-1:0]  cmd_q;
  logic [STAT_W-1:0] vis_stat;
  logic              df_q;
  logic              op_clear, op_load, op_go;
  logic              any_busy, cur_present, cur_wprot, cur_busy;
  logic [UNIT_W-1:0] cur_unit, sel_unit;
  tape_fn_e          cmd_fn;
  logic              start_try, wr_block, start_ok, abort, cont;

  assign op_clear = iot_valid_i && (iot_op_e'(iot_op_i) == IOP_CLEAR);
  assign op_load  = iot_valid_i && (iot_op_e'(iot_op_i) == IOP_LOAD);
  assign op_go    = iot_valid_i && (iot_op_e'(iot_op_i) == IOP_GO);

  tape_csr_cmd_reg i_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (op_clear),
    .load_i (op_load),
    .data_i (host_data_i),
    .cmd_o  (cmd_q)
  );

  assign sel_unit = cmd_q[CMD_UNIT_LSB +: UNIT_W];
  assign cmd_fn   = tape_fn_e'(cmd_q[CMD_FN_LSB +: 3]);

  tape_csr_unit_sel #(
    .NUM_DRIVES (NUM_DRIVES),
    .UNIT_W     (UNIT_W)
  ) i_unit_sel (
    .sel_unit_i    (sel_unit),
    .present_i     (drv_present_i),
    .wprot_i       (drv_wprot_i),
    .busy_i        (drv_busy_i),
    .any_busy_o    (any_busy),
    .cur_unit_o    (cur_unit),
    .cur_present_o (cur_present),
    .cur_wprot_o   (cur_wprot),
    .cur_busy_o    (cur_busy)
  );

  // with nothing busy the tracked drive is the selected one
  assign start_try = op_go && !any_busy && cmd_q[CMD_EN_BIT] && cur_present;
  assign wr_block  = fn_writes(cmd_fn) && cur_wprot;
  assign start_ok  = start_try && !wr_block;
  assign abort     = start_try && wr_block;
  assign cont      = op_go && any_busy;

  tape_csr_status i_status (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (op_clear),
    .start_i       (start_ok),
    .abort_i       (abort),
    .rewind_i      (cmd_fn == FN_REWIND),
    .df_set_i      (df_set_i),
    .df_clr_i      (op_go),
    .crc_set_i     (crc_err_i),
    .eof_set_i     (eof_i),
    .beot_set_i    (beot_i),
    .enable_i      (cmd_q[CMD_EN_BIT]),
    .cur_present_i (cur_present),
    .cur_wprot_i   (cur_wprot),
    .cur_busy_i    (cur_busy),
    .vis_stat_o    (vis_stat),
    .df_o          (df_q)
  );

  tape_csr_host_dec i_host_dec (
    .valid_i    (iot_valid_i),
    .op_i       (iot_op_i),
    .data_i     (host_data_i),
    .vis_stat_i (vis_stat),
    .df_i       (df_q),
    .ie_i       (cmd_q[CMD_IE_BIT]),
    .rd_data_o  (rd_data_o),
    .skip_o     (skip_o),
    .irq_o      (irq_o)
  );

  logic              go_start_q, go_cont_q;
  logic [2:0]        go_fn_q;
  logic [UNIT_W-1:0] go_unit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_start_q <= 1'b0;
      go_cont_q  <= 1'b0;
      go_fn_q    <= '0;
      go_unit_q  <= '0;
    end else begin
      go_start_q <= start_ok;
      go_cont_q  <= cont;
      if (start_ok || cont) begin
        go_fn_q   <= cmd_fn;
        go_unit_q <= sel_unit;
      end
    end
  end

  assign go_start_o = go_start_q;
  assign go_cont_o  = go_cont_q;
  assign go_fn_o    = go_fn_q;
  assign go_unit_o  = go_unit_q;
endmodule

// File: rtl/tape_csr_chk.sv
module tape_csr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       iot_valid_i,
  input logic [2:0] iot_op_i,
  input logic [7:0] host_data_i,
  input logic       df_set_i,
  input logic [7:0] cmd_q,
  input logic       df_q,
  input logic [7:0] rd_data_o,
  input logic       irq_o,
  input logic       go_start_o,
  input logic       go_cont_o
);
  // R2
  load_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iot_valid_i && iot_op_i == 3'd4) |=> (cmd_q == $past(host_data_i)));

  // R14
  clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iot_valid_i && iot_op_i == 3'd0) |=> (cmd_q == 8'd0 && !df_q));

  // R3
  masked_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_q[7] && iot_valid_i && iot_op_i == 3'd7) |-> (rd_data_o == 8'd0));

  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_q[0] |-> !irq_o);

  // R6
  df_go_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iot_valid_i && iot_op_i == 3'd6 && !df_set_i) |=> !df_q);

  // R12
  go_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({go_start_o, go_cont_o}));

  // R10
  go_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_start_o || go_cont_o) |-> $past(iot_valid_i && iot_op_i == 3'd6));
endmodule

bind tape_csr tape_csr_chk i_tape_csr_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iot_valid_i (iot_valid_i),
  .iot_op_i    (iot_op_i),
  .host_data_i (host_data_i),
  .df_set_i    (df_set_i),
  .cmd_q       (cmd_q),
  .df_q        (df_q),
  .rd_data_o   (rd_data_o),
  .irq_o       (irq_o),
  .go_start_o  (go_start_o),
  .go_cont_o   (go_cont_o)
);

// File: tb/test_tape_csr.sv
module test_tape_csr;
  logic clk_i = 1'b0;
  always #10 clk_i = ~clk_i;

  logic       rst_ni;
  logic       iot_valid_i;
  logic [2:0] iot_op_i;
  logic [7:0] host_data_i;
  logic [1:0] drv_present_i, drv_wprot_i, drv_busy_i;
  logic       df_set_i, crc_err_i, eof_i, beot_i;
  logic [7:0] rd_data_o;
  logic       skip_o, irq_o, go_start_o, go_cont_o;
  logic [2:0] go_fn_o;
  logic [0:0] go_unit_o;

  tape_csr #(.NUM_DRIVES(2)) i_tape_csr (
    .clk_i, .rst_ni, .iot_valid_i, .iot_op_i, .host_data_i,
    .drv_present_i, .drv_wprot_i, .drv_busy_i,
    .df_set_i, .crc_err_i, .eof_i, .beot_i,
    .rd_data_o, .skip_o, .irq_o, .go_start_o, .go_cont_o, .go_fn_o, .go_unit_o
  );

  int n_checks = 0;
  int n_fails = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_cmd;
  logic m_wle, m_crc, m_tim, m_beot, m_eof, m_rew, m_df;
  logic exp_gs, exp_gc;
  logic [2:0] exp_gfn;
  logic exp_gu;
  logic [7:0] obs_rd;
  logic obs_skip;

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] model_stat(logic [1:0] pres, logic [1:0] prot, logic [1:0] busy);
    logic u, rv, emp;
    logic [8:0] s;
    u = m_cmd[6];
    if (busy[1]) u = 1'b1;
    if (busy[0]) u = 1'b0;
    emp = !pres[u];
    rv = m_rew && pres[u] && busy[u];
    s = {m_wle, m_crc, m_tim, m_beot, m_eof, emp, rv, emp | prot[u] | rv, !busy[u]};
    return m_cmd[7] ? s : 9'd0;
  endfunction

  task automatic step(bit v, bit [2:0] op, bit [7:0] d = 8'h00, bit [1:0] pres = 2'b11,
                      bit [1:0] prot = 2'b00, bit [1:0] busy = 2'b00, bit dfs = 0,
                      bit crcs = 0, bit eofs = 0, bit beots = 0);
    logic [8:0] vs;
    logic [7:0] erd;
    logic [2:0] fn;
    bit anyerr, esk, eirq, is_go, n_gs, n_gc, do_start, do_abort, tim_hit;
    string stag;
    @(negedge clk_i);
    iot_valid_i = v; iot_op_i = op; host_data_i = d;
    drv_present_i = pres; drv_wprot_i = prot; drv_busy_i = busy;
    df_set_i = dfs; crc_err_i = crcs; eof_i = eofs; beot_i = beots;
    #1;
    chk("R10 go_start pulse", go_start_o, exp_gs);
    chk("R12 go_cont pulse", go_cont_o, exp_gc);
    if (exp_gs || exp_gc) begin
      chk("R10 go_fn", go_fn_o, exp_gfn);
      chk("R10 go_unit", go_unit_o, exp_gu);
    end
    vs = model_stat(pres, prot, busy);
    anyerr = |vs[8:3];
    obs_rd = rd_data_o;
    obs_skip = skip_o;
    if (v && op == 3'd4) begin
      erd = ~d;
      chk("R2 load return", rd_data_o, erd);
    end
    if (v && op == 3'd7) chk(m_cmd[7] ? "R4 status read" : "R3 masked read", rd_data_o, vs[7:0]);
    esk = 0;
    if (v) begin
      case (op)
        3'd1: esk = m_df;
        3'd2: esk = anyerr;
        3'd3: esk = vs[0] && !vs[3];
        3'd5: esk = m_df || anyerr || vs[0];
        default: esk = 0;
      endcase
    end
    stag = (op == 3'd1) ? "R6 skip df" : (op == 3'd2) ? "R7 skip error" : "R8 skip";
    chk(stag, skip_o, esk);
    eirq = m_cmd[0] && (m_df || anyerr || vs[0]);
    chk("R9 irq", irq_o, eirq);

    // next model state
    fn = m_cmd[5:3];
    is_go = v && op == 3'd6;
    n_gc = is_go && (busy != 2'b00);
    do_start = 0; do_abort = 0;
    if (is_go && busy == 2'b00 && m_cmd[7] && pres[m_cmd[6]]) begin
      if ((fn == 3'd2 || fn == 3'd4) && prot[m_cmd[6]]) do_abort = 1;
      else do_start = 1;
    end
    n_gs = do_start;
    tim_hit = dfs && m_df && !is_go;
    @(posedge clk_i);
    if (n_gs || n_gc) begin
      exp_gfn = fn;
      exp_gu = m_cmd[6];
    end
    exp_gs = n_gs;
    exp_gc = n_gc;
    if (v && op == 3'd0) begin
      m_cmd = 0; m_wle = 0; m_crc = 0; m_tim = 0; m_beot = 0; m_eof = 0; m_rew = 0; m_df = 0;
    end else begin
      if (v && op == 3'd4) m_cmd = d;
      if (do_start || do_abort) begin
        m_wle = 0; m_crc = 0; m_tim = 0; m_eof = 0; m_rew = 0;
      end
      if (do_abort) m_wle = 1;
      if (do_start) begin
        m_beot = 0;
        m_rew = (fn == 3'd1);
      end
      if (is_go) m_df = 0;
      if (dfs) m_df = 1;
      if (tim_hit) m_tim = 1;
      if (crcs) m_crc = 1;
      if (eofs) m_eof = 1;
      if (beots) m_beot = 1;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    m_cmd = 0; m_wle = 0; m_crc = 0; m_tim = 0; m_beot = 0; m_eof = 0; m_rew = 0; m_df = 0;
    exp_gs = 0; exp_gc = 0; exp_gfn = 0; exp_gu = 0;
    rst_ni = 1'b0;
    iot_valid_i = 0; iot_op_i = 0; host_data_i = 0;
    drv_present_i = 2'b11; drv_wprot_i = 0; drv_busy_i = 0;
    df_set_i = 0; crc_err_i = 0; eof_i = 0; beot_i = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 irq after reset", irq_o, 0);
    chk("R1 skip after reset", skip_o, 0);
    chk("R1 go_start after reset", go_start_o, 0);
    chk("R1 go_cont after reset", go_cont_o, 0);
    step(1, 3'd7);
    chk("R1 status after reset", obs_rd, 8'h00);

    // R2 load returns complement
    step(1, 3'd4, 8'h5A);
    chk("R2 load complement", obs_rd, 8'hA5);
    // R3 enable clear hides an empty drive
    step(1, 3'd7, 8'h00, 2'b00);
    chk("R3 masked status", obs_rd, 8'h00);
    step(1, 3'd3, 8'h00, 2'b00);
    chk("R3 ready skip masked", obs_skip, 0);

    // R4 empty selected drive
    step(1, 3'd4, 8'h81);
    step(1, 3'd7, 8'h00, 2'b10);
    chk("R4 empty drive status", obs_rd, 8'h0B);
    // R5 protected drive
    step(1, 3'd7, 8'h00, 2'b11, 2'b01);
    chk("R5 protected status", obs_rd, 8'h03);

    // R10 rewind start, then shown rewinding while busy
    step(1, 3'd4, 8'h88);
    step(1, 3'd6);
    step(1, 3'd7, 8'h00, 2'b11, 2'b00, 2'b01);
    chk("R10 rewinding status", obs_rd, 8'h06);
    // R12 continue while busy
    step(1, 3'd6, 8'h00, 2'b11, 2'b00, 2'b01);
    step(0, 3'd0, 8'h00, 2'b11, 2'b00, 2'b01, 0, 0, 0, 1);
    chk("R12 continue pulse", go_cont_o, 1);

    // R11 write on protected drive aborts, BOT/EOT kept
    step(1, 3'd4, 8'h90, 2'b11, 2'b01);
    step(1, 3'd6, 8'h00, 2'b11, 2'b01);
    step(1, 3'd2, 8'h00, 2'b11, 2'b01);
    chk("R11 write-lock error skip", obs_skip, 1);
    chk("R11 no start pulse", go_start_o, 0);
    step(1, 3'd7, 8'h00, 2'b11, 2'b01);
    chk("R11 status keeps beot", obs_rd, 8'h23);

    // R13 data flag overrun sets timing error
    step(1, 3'd4, 8'h80);
    step(1, 3'd6);
    step(0, 3'd0, 8'h00, 2'b11, 2'b00, 2'b00, 1);
    step(0, 3'd0, 8'h00, 2'b11, 2'b00, 2'b00, 1);
    step(1, 3'd7);
    chk("R13 timing error status", obs_rd, 8'h41);
    step(1, 3'd1);
    chk("R6 data flag skip", obs_skip, 1);

    // R14 clear
    step(1, 3'd0);
    step(1, 3'd1);
    chk("R14 data flag cleared", obs_skip, 0);
    step(1, 3'd4, 8'h80);
    step(1, 3'd7);
    chk("R14 sticky bits cleared", obs_rd, 8'h01);

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      bit [2:0] op;
      bit [7:0] d;
      bit [1:0] pres, prot, busy;
      op = 3'($urandom_range(0, 7));
      if (op == 3'd0 && $urandom_range(0, 9) != 0) op = 3'd7;
      d = 8'($urandom);
      if ($urandom_range(0, 3) != 0) d[7] = 1'b1;
      pres = ($urandom_range(0, 4) == 0) ? 2'($urandom) : 2'b11;
      prot = 2'($urandom);
      busy = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
      step($urandom_range(0, 5) != 0, op, d, pres, prot, busy,
           $urandom_range(0, 4) == 0, $urandom_range(0, 19) == 0,
           $urandom_range(0, 19) == 0, $urandom_range(0, 19) == 0);
    end
    step(0, 3'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule